// File: doc/BRIEF.md
# Register Bank Peripheral with Programmable Wait States

This block is a peripheral on an APB bus. It holds a small bank of 32-bit registers. Six of them store values written by the bus. Two return status words that the surrounding logic supplies on an input port, and the bus cannot change them. A transfer begins with a setup cycle, in which the select is high and the enable is low. The access phase follows, with select and enable both high. The block acts only in the access phase.

A 3-bit input sets how many cycles the block holds `pready` low before it completes a transfer. A value of zero completes the transfer on the first access-phase cycle. Some accesses cannot be honoured: an address outside the map, an address that is not word aligned, or a write to a status word. Each of these still completes, with `pslverr` high, and leaves every stored register as it was.

The control is a two-state machine:
- `ST_IDLE` waits for the first access-phase cycle. If the wait count is zero, it completes the transfer in that cycle and stays in `ST_IDLE` (transition *finish-now*). Otherwise it loads the count minus one and moves to `ST_STALL` (transition *begin-stall*).
- `ST_STALL` counts down while the access phase lasts. When the count reaches zero it completes the transfer and returns to `ST_IDLE` (transition *finish-late*). If the select or the enable drops before then, it returns to `ST_IDLE` without completing anything (transition *abandon*).

Top module: `apb_regbank`

## Requirements
- R1: After reset, `pready`, `pslverr` and `prdata` are low, and registers 0 to 5 all read as zero.
- R2: When `wait_cfg` is 0 on the first access-phase cycle, `pready` is high in that same cycle.
- R3: When `wait_cfg` is N (1 to 7) on the first access-phase cycle, `pready` stays low for N access-phase cycles and goes high on cycle N+1.
- R4: Register k sits at byte offset 4*k, address bits [4:2] being the index. A write to any of registers 0 to 5 stores `pwdata` on the completing cycle without error. A later read of that register returns the value, and the other registers keep their contents.
- R5: An access is outside the map when any address bit above bit 4 is set, or when bits [1:0] are not zero. Such an access completes with `pslverr` high, changes no register, and a read of this kind returns zero.
- R6: A write to offset 0x18 or 0x1C completes with `pslverr` high and changes no register.
- R7: A read of offset 0x18 returns `ro_status[0]`, and a read of offset 0x1C returns `ro_status[1]`. The value is the one present on the port at that moment, and `pslverr` stays low.
- R8: `prdata` is zero on every cycle except the completing cycle of a read without error.
- R9: `pslverr` and `pready` are low on every cycle that does not complete a transfer, including setup cycles and wait cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the block acts on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| psel | input | 1 | Selects this peripheral for a transfer |
| penable | input | 1 | High during the access phase |
| paddr | input | 12 | Byte address |
| pwrite | input | 1 | High for a write, low for a read |
| pwdata | input | 32 | Write data |
| wait_cfg | input | 3 | Number of wait cycles to insert |
| ro_status | input | 64 | Two packed 32-bit status words, read at 0x18 and 0x1C |
| prdata | output | 32 | Read data |
| pready | output | 1 | High on the cycle that completes the transfer |
| pslverr | output | 1 | Error flag, valid together with `pready` |

## Verification
The assertions rely on the requester following the bus rules:
- Every access phase comes after exactly one setup cycle.
- The enable never stays high from one completed transfer into the next.
- `wait_cfg`, the address and the write flag stay stable for the whole transfer.

The first access-phase cycle is recognised by the enable and the select rising together after a cycle in which they were not both high. That detection is correct only under these rules. The bench keeps within them through a single transfer task. The task drives a setup cycle, then the access phase. It holds every control input until the completing cycle and returns to idle afterwards.

// File: rtl/apb_rb_pkg.sv
package apb_rb_pkg;

    // Control states of the transfer engine
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_STALL = 1'b1
    } rb_state_e;

endpackage

// File: rtl/apb_rb_fsm.sv
module apb_rb_fsm
    import apb_rb_pkg::*;
#(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic [WAIT_W-1:0] wait_cfg,
    output logic              done
);

    rb_state_e         state_q, state_d;
    logic [WAIT_W-1:0] cnt_q, cnt_d;
    logic              access;

    assign access = psel & penable;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (access && (wait_cfg != '0)) begin
                    state_d = ST_STALL;
                    cnt_d   = wait_cfg - 1'b1;
                end
            end
            ST_STALL: begin
                if (!access) begin
                    state_d = ST_IDLE;
                end else if (cnt_q == '0) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        done = 1'b0;
        unique case (state_q)
            ST_IDLE:  done = access && (wait_cfg == '0);
            ST_STALL: done = access && (cnt_q == '0);
        endcase
    end

endmodule

// File: rtl/apb_rb_decode.sv
module apb_rb_decode #(
    parameter int ADDR_W = 12,
    parameter int N_RW   = 6,
    parameter int N_REG  = 8,
    parameter int IDX_W  = 3
) (
    input  logic [ADDR_W-1:0] paddr,
    input  logic              pwrite,
    output logic [IDX_W-1:0]  idx,
    output logic              err
);

    localparam int MAP_BITS = IDX_W + 2;

    logic outside, misaligned, read_only;

    assign idx        = paddr[MAP_BITS-1:2];
    assign misaligned = |paddr[1:0];

    always_comb begin
        outside = |paddr[ADDR_W-1:MAP_BITS];
        if (int'(idx) >= N_REG) outside = 1'b1;
    end

    assign read_only = (int'(idx) >= N_RW);
    assign err       = outside | misaligned | (pwrite & read_only);

endmodule

// File: rtl/apb_rb_store.sv
module apb_rb_store #(
    parameter int DATA_W = 32,
    parameter int N_RW   = 6,
    parameter int N_RO   = 2,
    parameter int IDX_W  = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            idx,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [N_RO-1:0][DATA_W-1:0] ro_vals,
    output logic [DATA_W-1:0]           rd_val
);

    logic [DATA_W-1:0] rw_q [N_RW];

    for (genvar g = 0; g < N_RW; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rw_q[g] <= '0;
            end else if (wr_en && (int'(idx) == g)) begin
                rw_q[g] <= wdata;
            end
        end
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < N_RW; i++) begin
            if (int'(idx) == i) rd_val = rw_q[i];
        end
        for (int j = 0; j < N_RO; j++) begin
            if (int'(idx) == N_RW + j) rd_val = ro_vals[j];
        end
    end

endmodule

// File: rtl/apb_regbank.sv
module apb_regbank #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int N_RW   = 6,
    parameter int N_RO   = 2,
    parameter int WAIT_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        psel,
    input  logic                        penable,
    input  logic [ADDR_W-1:0]           paddr,
    input  logic                        pwrite,
    input  logic [DATA_W-1:0]           pwdata,
    input  logic [WAIT_W-1:0]           wait_cfg,
    input  logic [N_RO-1:0][DATA_W-1:0] ro_status,
    output logic [DATA_W-1:0]           prdata,
    output logic                        pready,
    output logic                        pslverr
);

    localparam int N_REG = N_RW + N_RO;
    localparam int IDX_W = (N_REG > 1) ? $clog2(N_REG) : 1;

    logic              done;
    logic              err;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] rd_val;
    logic              wr_en;

    apb_rb_fsm #(.WAIT_W(WAIT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .psel     (psel),
        .penable  (penable),
        .wait_cfg (wait_cfg),
        .done     (done)
    );

    apb_rb_decode #(
        .ADDR_W (ADDR_W),
        .N_RW   (N_RW),
        .N_REG  (N_REG),
        .IDX_W  (IDX_W)
    ) u_dec (
        .paddr  (paddr),
        .pwrite (pwrite),
        .idx    (idx),
        .err    (err)
    );

    assign wr_en = done & pwrite & ~err;

    apb_rb_store #(
        .DATA_W (DATA_W),
        .N_RW   (N_RW),
        .N_RO   (N_RO),
        .IDX_W  (IDX_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .idx     (idx),
        .wdata   (pwdata),
        .ro_vals (ro_status),
        .rd_val  (rd_val)
    );

    assign pready  = done;
    assign pslverr = done & err;
    assign prdata  = (done && !pwrite && !err) ? rd_val : '0;

endmodule

// File: rtl/apb_regbank_chk.sv
module apb_regbank_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int WAIT_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic [ADDR_W-1:0] paddr,
    input logic              pwrite,
    input logic [WAIT_W-1:0] wait_cfg,
    input logic [DATA_W-1:0] prdata,
    input logic              pready,
    input logic              pslverr
);

    // first access-phase cycle, zero waits: completes at once (R2)
    p_zero_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && !$past(psel && penable) && wait_cfg == '0) |-> pready);

    // first access-phase cycle, non-zero waits: stretched (R3)
    p_stretch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && !$past(psel && penable) && wait_cfg != '0) |-> !pready);

    // out-of-map or misaligned address reports an error (R5)
    p_bad_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pready && ((|paddr[ADDR_W-1:5]) || (|paddr[1:0]))) |-> pslverr);

    // read data only on a completing read without error (R8)
    p_rdata_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pready && !pwrite && !pslverr) |-> (prdata == '0));

    // error flag only with completion (R9)
    p_err_with_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |-> pready);

    // completion only inside an access phase (R9)
    p_ready_in_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pready |-> (psel && penable));

endmodule

bind apb_regbank apb_regbank_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .WAIT_W (WAIT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .psel     (psel),
    .penable  (penable),
    .paddr    (paddr),
    .pwrite   (pwrite),
    .wait_cfg (wait_cfg),
    .prdata   (prdata),
    .pready   (pready),
    .pslverr  (pslverr)
);

// File: tb/test_apb_regbank.sv
module test_apb_regbank;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             psel = 1'b0;
    logic             penable = 1'b0;
    logic [11:0]      paddr = '0;
    logic             pwrite = 1'b0;
    logic [31:0]      pwdata = '0;
    logic [2:0]       wait_cfg = '0;
    logic [1:0][31:0] ro_status;
    logic [31:0]      prdata;
    logic             pready;
    logic             pslverr;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    apb_regbank i_apb_regbank (
        .clk       (clk),
        .rst_n     (rst_n),
        .psel      (psel),
        .penable   (penable),
        .paddr     (paddr),
        .pwrite    (pwrite),
        .pwdata    (pwdata),
        .wait_cfg  (wait_cfg),
        .ro_status (ro_status),
        .prdata    (prdata),
        .pready    (pready),
        .pslverr   (pslverr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One transfer: setup cycle, then access phase until pready.
    // Also checks that non-completing cycles are quiet (R8, R9).
    task automatic xfer(input logic [11:0] a, input logic w, input logic [31:0] d,
                        input logic [2:0] n, output logic [31:0] rd,
                        output logic er, output int waits);
        logic noisy = 1'b0;
        @(negedge clk);
        paddr = a; pwrite = w; pwdata = d; wait_cfg = n;
        psel = 1'b1; penable = 1'b0;
        #5;
        if (pready || pslverr || prdata != 0) noisy = 1'b1;
        @(negedge clk);
        penable = 1'b1;
        waits = 0;
        rd = '0; er = 1'b0;
        while (waits < 20) begin
            #5;
            if (pready) begin
                rd = prdata;
                er = pslverr;
                break;
            end
            if (pslverr || prdata != 0) noisy = 1'b1;
            waits++;
            @(negedge clk);
        end
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
        chk("R9 quiet non-completing cycles", {31'd0, noisy}, 32'd0);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [2:0] n,
                      input logic exp_err, input string tag);
        logic [31:0] rd; logic er; int wt;
        xfer(a, 1'b1, d, n, rd, er, wt);
        chk(tag, {31'd0, er}, {31'd0, exp_err});
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input logic [2:0] n,
                          input logic exp_err, input string tag);
        logic [31:0] rd; logic er; int wt;
        xfer(a, 1'b0, 32'd0, n, rd, er, wt);
        chk(tag, rd, exp);
        chk(tag, {31'd0, er}, {31'd0, exp_err});
    endtask

    task automatic t_reset();
        @(negedge clk); #5;
        chk("R1 pready after reset", {31'd0, pready}, 32'd0);
        chk("R1 pslverr after reset", {31'd0, pslverr}, 32'd0);
        chk("R1 prdata after reset", prdata, 32'd0);
        rst_n = 1'b1;
        for (int k = 0; k < 6; k++) rd_chk(12'(4 * k), 32'd0, 3'd0, 1'b0, "R1 reg zero");
    endtask

    task automatic t_zero_wait();
        logic [31:0] rd; logic er; int wt;
        xfer(12'h00C, 1'b1, 32'h0000_1234, 3'd0, rd, er, wt);
        chk("R2 write no wait", 32'(wt), 32'd0);
        xfer(12'h00C, 1'b0, 32'd0, 3'd0, rd, er, wt);
        chk("R2 read no wait", 32'(wt), 32'd0);
        chk("R2 read value", rd, 32'h0000_1234);
    endtask

    task automatic t_waits();
        logic [31:0] rd; logic er; int wt;
        for (int n = 1; n < 8; n++) begin
            xfer(12'h00C, 1'b0, 32'd0, 3'(n), rd, er, wt);
            chk("R3 wait count", 32'(wt), 32'(n));
            chk("R3 data after wait", rd, 32'h0000_1234);
        end
        xfer(12'h004, 1'b1, 32'hBEEF_0001, 3'd5, rd, er, wt);
        chk("R3 write wait count", 32'(wt), 32'd5);
    endtask

    task automatic t_rw();
        for (int k = 0; k < 6; k++) wr(12'(4 * k), 32'hC0DE_0000 | 32'(k * 17), 3'(k % 4), 1'b0, "R4 write ok");
        for (int k = 0; k < 6; k++) rd_chk(12'(4 * k), 32'hC0DE_0000 | 32'(k * 17), 3'(k % 3), 1'b0, "R4 readback");
        wr(12'h008, 32'h5555_AAAA, 3'd2, 1'b0, "R4 overwrite");
        for (int k = 0; k < 6; k++)
            rd_chk(12'(4 * k), (k == 2) ? 32'h5555_AAAA : (32'hC0DE_0000 | 32'(k * 17)), 3'd0, 1'b0, "R4 others kept");
    endtask

    task automatic t_oob();
        wr(12'h020, 32'hFFFF_FFFF, 3'd0, 1'b1, "R5 write past map");
        wr(12'h800, 32'hFFFF_FFFF, 3'd3, 1'b1, "R5 write high address");
        wr(12'h00A, 32'hFFFF_FFFF, 3'd1, 1'b1, "R5 write misaligned");
        rd_chk(12'h040, 32'd0, 3'd2, 1'b1, "R5 read past map");
        rd_chk(12'h001, 32'd0, 3'd0, 1'b1, "R5 read misaligned");
        for (int k = 0; k < 6; k++)
            rd_chk(12'(4 * k), (k == 2) ? 32'h5555_AAAA : (32'hC0DE_0000 | 32'(k * 17)), 3'd0, 1'b0, "R5 regs unchanged");
    endtask

    task automatic t_ro();
        wr(12'h018, 32'h1111_2222, 3'd1, 1'b1, "R6 write status 0");
        wr(12'h01C, 32'h3333_4444, 3'd0, 1'b1, "R6 write status 1");
        rd_chk(12'h018, 32'hA5A5_0001, 3'd0, 1'b0, "R7 status 0");
        rd_chk(12'h01C, 32'h5A5A_0002, 3'd4, 1'b0, "R7 status 1");
        ro_status[0] = 32'h0BAD_F00D;
        ro_status[1] = 32'h600D_CAFE;
        rd_chk(12'h018, 32'h0BAD_F00D, 3'd0, 1'b0, "R7 status 0 live");
        rd_chk(12'h01C, 32'h600D_CAFE, 3'd7, 1'b0, "R7 status 1 live");
        for (int k = 0; k < 6; k++)
            rd_chk(12'(4 * k), (k == 2) ? 32'h5555_AAAA : (32'hC0DE_0000 | 32'(k * 17)), 3'd0, 1'b0, "R6 regs unchanged");
    endtask

    task automatic t_idle();
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = 12'h004;
        #5;
        chk("R8 prdata in setup", prdata, 32'd0);
        chk("R9 pready in setup", {31'd0, pready}, 32'd0);
        @(negedge clk);
        psel = 1'b0;
        #5;
        chk("R8 prdata idle", prdata, 32'd0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog (all R): actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        ro_status[0] = 32'hA5A5_0001;
        ro_status[1] = 32'h5A5A_0002;
        repeat (3) @(negedge clk);
        t_reset();
        t_zero_wait();
        t_waits();
        t_rw();
        t_oob();
        t_ro();
        t_idle();
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

endmodule